// File: doc/BRIEF.md
# Fused Two-Thread Instruction Arbiter

This block sits in front of a vector processor that has a single physical instruction input. It presents two virtual input channels. Each channel is an instruction queue with its own logical thread. A host writes instructions through one valid/ready port. In split mode, a thread select bit decides which queue takes each instruction. In fused mode, every accepted instruction is written into both queues at once. One host instruction stream therefore runs as two logical threads, each working in its own virtual register and memory space.

A round-robin picker drains the two queues onto one valid/ready output. Before sending an instruction, the block overwrites its least significant bit with the index of the queue it came from. That bit is the thread tag read further down the pipeline. An instruction offered on the output stays there until the consumer takes it. The fuse switch and the thread select are host-set state and are meant to be changed between threads.

Top module: `instr_fuse_arbiter`

## Requirements
- R1: After reset both queues are empty: `out_valid` is 0 and `host_ready` is 1.
- R2: With `fuse_en` low, an accepted host instruction goes only into the queue picked by `thread_sel` (0 or 1). It leaves the output tagged with that index.
- R3: With `fuse_en` high, each accepted host instruction comes out twice, once tagged 0 and once tagged 1.
- R4: With `fuse_en` high, `host_ready` is 1 only when both queues have a free entry, so the two copies are never split.
- R5: With `fuse_en` low, `host_ready` depends only on the selected queue. A full unselected queue does not stall the host.
- R6: When both queues hold instructions, the output alternates between them. The preferred queue changes only on a completed output transfer (`out_valid` and `out_ready` both 1), and then moves to the other queue.
- R7: When exactly one queue holds instructions, that queue is served every cycle the consumer is ready. `out_valid` is 1 exactly when at least one queue is non-empty.
- R8: `out_instr[0]` carries the source queue index. `out_instr[INSTR_W-1:1]` equals the same bits of the host instruction. The host's bit 0 is dropped. Each queue is first-in first-out.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_instr` unchanged. No instruction is removed without a transfer.
- R10: Each queue holds exactly `DEPTH` (default 8) instructions. Once it is full, the host is held off for it, so nothing is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fuse_en | input | 1 | 1: copy each host instruction into both queues |
| thread_sel | input | 1 | Target queue when `fuse_en` is 0 |
| host_valid | input | 1 | Host instruction present |
| host_instr | input | INSTR_W | Host instruction word |
| host_ready | output | 1 | Host instruction accepted this cycle when high with `host_valid` |
| out_valid | output | 1 | Tagged instruction on the output |
| out_instr | output | INSTR_W | Instruction with thread tag in bit 0 |
| out_ready | input | 1 | Consumer takes the instruction this cycle |

## Verification
A behavioural model with one queue per thread predicts `out_valid`, `out_instr` and `host_ready` every cycle. Split traffic on a single thread with an always-ready consumer exercises routing and back-to-back service. Split traffic with a random thread select and a random consumer stall mixes both queues, which tests alternation and holding a stalled output. Fused traffic against a stopped consumer fills both queues to the limit. This separates joint back-pressure from per-queue back-pressure. Filling one queue and then switching the select to the other shows the host is not stalled by the unselected queue. A final random phase toggles every control input.

// File: rtl/fuse_arb_pkg.sv
package fuse_arb_pkg;
   localparam int unsigned NUM_LANES = 2;
   typedef logic [0:0] lane_id_t;

   function automatic lane_id_t other_lane(input lane_id_t id);
      return ~id;
   endfunction
endpackage

// File: rtl/fuse_lane_fifo.sv
module fuse_lane_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fuse_lane_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] fill_q;
   logic             do_push, do_pop;

   assign full    = (fill_q == CNT_W'(DEPTH));
   assign empty   = (fill_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = store[rd_q];

   always_ff @(posedge clk) begin
      if (do_push) store[wr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= '0;
         rd_q   <= '0;
         fill_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end
endmodule

// File: rtl/fuse_rr_pick.sv
module fuse_rr_pick
   import fuse_arb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LANES-1:0] req,
   input  logic                 take,
   input  logic                 stall,
   output lane_id_t             gnt_id
);
   lane_id_t pref_q, held_id_q;
   logic     held_q;

   always_comb begin
      if (held_q)            gnt_id = held_id_q;
      else if (&req)         gnt_id = pref_q;
      else if (req[0])       gnt_id = lane_id_t'(0);
      else                   gnt_id = lane_id_t'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pref_q    <= lane_id_t'(0);
         held_q    <= 1'b0;
         held_id_q <= lane_id_t'(0);
      end else begin
         if (take) pref_q <= other_lane(gnt_id);
         held_q    <= stall;
         held_id_q <= gnt_id;
      end
   end
endmodule

// File: rtl/instr_fuse_arbiter.sv
module instr_fuse_arbiter
   import fuse_arb_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned DEPTH   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fuse_en,
   input  logic               thread_sel,
   input  logic               host_valid,
   input  logic [INSTR_W-1:0] host_instr,
   output logic               host_ready,
   output logic               out_valid,
   output logic [INSTR_W-1:0] out_instr,
   input  logic               out_ready
);
   if (INSTR_W < 2) begin : g_bad_width
      $error("instr_fuse_arbiter: INSTR_W must leave room for the thread tag");
   end

   logic [NUM_LANES-1:0] push_v, pop_v, full_v, empty_v;
   logic [INSTR_W-1:0]   head_v [NUM_LANES];
   lane_id_t             gnt_id;
   logic                 take, stall;

   assign host_ready = fuse_en ? !(|full_v) : !full_v[thread_sel];

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign push_v[i] = host_valid && host_ready
                         && (fuse_en || (thread_sel == 1'(i)));
      assign pop_v[i]  = take && (gnt_id == lane_id_t'(i));

      fuse_lane_fifo #(
         .WIDTH (INSTR_W),
         .DEPTH (DEPTH)
      ) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push_v[i]),
         .din   (host_instr),
         .pop   (pop_v[i]),
         .dout  (head_v[i]),
         .full  (full_v[i]),
         .empty (empty_v[i])
      );
   end

   assign out_valid = !(&empty_v);
   assign take      = out_valid && out_ready;
   assign stall     = out_valid && !out_ready;

   fuse_rr_pick u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (~empty_v),
      .take   (take),
      .stall  (stall),
      .gnt_id (gnt_id)
   );

   assign out_instr = {head_v[gnt_id][INSTR_W-1:1], gnt_id};
endmodule

// File: rtl/fuse_arb_chk.sv
module fuse_arb_chk #(
   parameter int unsigned INSTR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fuse_en,
   input logic               host_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [INSTR_W-1:0] out_instr,
   input logic [1:0]         full_v,
   input logic [1:0]         empty_v,
   input logic [1:0]         push_v
);
   // R4
   fused_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_en && host_ready) |-> (full_v == 2'b00));

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_v[0] |-> !push_v[0]);

   // R10
   no_overflow1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_v[1] |-> !push_v[1]);

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_instr)));

   // R7
   valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (empty_v != 2'b11));

   // R8
   tag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !empty_v[out_instr[0]]);
endmodule

bind instr_fuse_arbiter fuse_arb_chk #(.INSTR_W(INSTR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fuse_en    (fuse_en),
   .host_ready (host_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_instr  (out_instr),
   .full_v     (full_v),
   .empty_v    (empty_v),
   .push_v     (push_v)
);

// File: tb/tb_instr_fuse_arbiter.sv
`timescale 1ns/1ps
module tb_instr_fuse_arbiter;
   localparam int W = 32;
   localparam int D = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         fuse_en, thread_sel, host_valid, out_ready;
   logic [W-1:0] host_instr;
   logic         host_ready, out_valid;
   logic [W-1:0] out_instr;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   instr_fuse_arbiter #(.INSTR_W(W), .DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .fuse_en(fuse_en), .thread_sel(thread_sel),
      .host_valid(host_valid), .host_instr(host_instr), .host_ready(host_ready),
      .out_valid(out_valid), .out_instr(out_instr), .out_ready(out_ready)
   );

   // reference model state
   logic [W-1:0] mq0[$];
   logic [W-1:0] mq1[$];
   int  pref = 0;
   bit  held = 0;
   int  held_id = 0;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int qsize(input int id);
      return (id == 0) ? mq0.size() : mq1.size();
   endfunction

   // one cycle: inputs already driven after a negedge
   task automatic step(input string tag);
      bit e_valid, e_ready, take, acc;
      int gid;
      logic [W-1:0] e_instr;
      #1;
      e_valid = (mq0.size() != 0) || (mq1.size() != 0);
      if (held) gid = held_id;
      else if (mq0.size() != 0 && mq1.size() != 0) gid = pref;
      else if (mq0.size() != 0) gid = 0;
      else gid = 1;
      e_instr = '0;
      if (e_valid) begin
         e_instr = (gid == 0) ? mq0[0] : mq1[0];
         e_instr[0] = gid[0];
      end
      e_ready = fuse_en ? (mq0.size() < D && mq1.size() < D)
                        : (qsize(thread_sel ? 1 : 0) < D);
      // R7 valid whenever a queue is non-empty
      check({tag, " R7 out_valid"}, W'(out_valid), W'(e_valid));
      // R8 tag and payload, R6 alternation, R3 duplication
      if (e_valid) check({tag, " R8 out_instr"}, out_instr, e_instr);
      // R4 fused ready, R5 split ready, R10 depth
      check({tag, fuse_en ? " R4 host_ready" : " R5 host_ready"}, W'(host_ready), W'(e_ready));
      take = e_valid && out_ready;
      acc  = host_valid && e_ready;
      @(posedge clk);
      if (take) begin
         if (gid == 0) void'(mq0.pop_front()); else void'(mq1.pop_front());
         pref = 1 - gid;
      end
      held    = e_valid && !out_ready;
      held_id = gid;
      if (acc) begin
         if (fuse_en || !thread_sel) mq0.push_back(host_instr);
         if (fuse_en || thread_sel)  mq1.push_back(host_instr);
      end
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; fuse_en = 0; thread_sel = 0; host_valid = 0; out_ready = 0;
      host_instr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      check("R1 out_valid", W'(out_valid), '0);
      check("R1 host_ready", W'(host_ready), W'(1));

      // R2 split routing to thread 0, always-ready consumer (R7)
      for (int i = 0; i < 200; i++) begin
         fuse_en = 0; thread_sel = 0; out_ready = 1;
         host_valid = ($urandom % 3) != 0; host_instr = $urandom;
         step("R2");
      end
      // R6 and R9: mixed threads, random stall
      for (int i = 0; i < 600; i++) begin
         fuse_en = 0; thread_sel = $urandom; out_ready = $urandom;
         host_valid = $urandom; host_instr = $urandom;
         step("R6 R9");
      end
      // R3, R4, R10: fused traffic against a stopped consumer
      for (int i = 0; i < 20; i++) begin
         fuse_en = 1; out_ready = 0; host_valid = 1; host_instr = $urandom;
         step("R3 R10");
      end
      for (int i = 0; i < 60; i++) begin
         fuse_en = 1; out_ready = 1; host_valid = ($urandom % 4) == 0;
         host_instr = $urandom;
         step("R3");
      end
      // R5: fill queue 1, then host to queue 0 is still accepted
      for (int i = 0; i < 40; i++) begin
         fuse_en = 0; thread_sel = 1; out_ready = 0; host_valid = 1;
         host_instr = $urandom;
         step("R5 R10");
      end
      for (int i = 0; i < 12; i++) begin
         fuse_en = 0; thread_sel = 0; out_ready = 0; host_valid = 1;
         host_instr = $urandom;
         step("R5");
      end
      // everything random
      for (int i = 0; i < 3000; i++) begin
         fuse_en = ($urandom % 4) == 0; thread_sel = $urandom;
         out_ready = ($urandom % 3) != 0; host_valid = $urandom;
         host_instr = $urandom;
         step("R2 R3 R6");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule